// File: doc/BRIEF.md
# Processor idle state sequencer

This block sequences the sideband wires that put a processor into its low-power states and bring it back. Software posts a request for one of four sleep targets: a halt with the clock running (C2), a halt with the clock stopped (C3), the same with the core voltage lowered (C4), or the light system sleep (S1). The block then walks an ordered entry sequence. It asserts the stop-clock line first and waits for the processor to acknowledge that it has halted. After that it asserts deep-sleep, then clock-stop, then the voltage-lower request, and a programmable settle count separates each step from the next.

A wake or break event unwinds the steps in the reverse order, with the same settle spacing. From the deep-sleep step until its release, a memory-block flag tells the other bus masters that memory must not be accessed. In the full-on state the block can throttle the processor instead. For this it pulses the stop-clock line with a programmable duty cycle. A request is only taken in the full-on state. If the acknowledge never comes, the block gives up, releases the stop-clock line and flags an error.

Top module: `cpu_idle_seq`

## Requirements
- R1: During reset and directly after it, the five sideband outputs (stpclk_n, dpslp_n, stpcpu_n, cpuslp_n, vlow_n) are high, mem_block is low and seq_err is low.
- R2: The target is coded on req_state as 1 = C2, 2 = C3, 3 = C4 and 4 = S1; 0 and 5..7 do nothing. A request pulse sampled at edge r in the full-on state drives stpclk_n low at edge r+1. For C2, no other output changes.
- R3: For C3 and C4, dpslp_n falls settle+1 edges after the edge that samples sg_ack high. stpcpu_n falls settle+1 edges after dpslp_n. stpcpu_n is never low while dpslp_n is high, and dpslp_n is never low while stpclk_n is high.
- R4: mem_block rises on the same edge as dpslp_n falls and drops on the same edge as dpslp_n rises. It is high exactly while dpslp_n is low.
- R5: For C4, vlow_n falls settle+1 edges after stpcpu_n. vlow_n is never low while stpcpu_n is high.
- R6: For S1, only stpclk_n is driven low, unless s1_sleep_en is 1 when the acknowledge is sampled. In that case cpuslp_n also falls settle+1 edges after the acknowledge edge.
- R7: A wake pulse sampled at edge w in residence releases the deepest asserted output at edge w+settle+2. The order is vlow_n, stpcpu_n, dpslp_n, cpuslp_n, stpclk_n, and each later release comes settle+1 edges after the one before.
- R8: In the full-on state with thr_duty = D, stpclk_n is low for exactly D*(thr_period+1) cycles out of every 8*(thr_period+1). With D = 0 it stays high.
- R9: stpclk_n falls at edge k. If sg_ack is not high at any edge k+1 .. k+ack_timeout+1, stpclk_n is released and seq_err is set at edge k+ack_timeout+1. An acknowledge at that last edge still wins. seq_err clears when the next sleep request is accepted.
- R10: A request that arrives outside the full-on state is held, and the latest one wins. It starts one edge after the exit sequence returns to the full-on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe posting a state request |
| req_state | input | 3 | Requested target (1 C2, 2 C3, 3 C4, 4 S1) |
| s1_sleep_en | input | 1 | Also drive cpuslp_n during S1 |
| thr_duty | input | 3 | Throttle slots with stop-clock asserted out of 8 |
| thr_period | input | PER_W | Throttle slot length minus one |
| settle | input | SET_W | Settle count between sequence steps |
| ack_timeout | input | TO_W | Acknowledge wait limit |
| sg_ack | input | 1 | Stop-Grant acknowledge from the processor |
| wake | input | 1 | Break or wake event |
| stpclk_n | output | 1 | Stop-clock request, active low |
| dpslp_n | output | 1 | Deep-sleep request, active low |
| stpcpu_n | output | 1 | Processor clock stop, active low |
| cpuslp_n | output | 1 | Processor sleep for S1, active low |
| vlow_n | output | 1 | Voltage-lower request, active low |
| mem_block | output | 1 | Other masters must not access memory |
| seq_err | output | 1 | Acknowledge timed out |

## Verification
Two functions meet in one cycle: the acknowledge arrives and the acknowledge wait count runs out. The bench turns off its automatic responder and raises sg_ack exactly ack_timeout cycles after stop-clock goes low. At the cycle before, stop-clock must still be asserted with no error. After the collision edge, deep-sleep must follow and the error must stay clear. A second collision is a request that lands while a residence is in progress. Its start is timed to exactly one cycle after the exit sequence releases stop-clock.

// File: rtl/idle_seq_pkg.sv
// Shared types for the processor idle state sequencer.
// Assumes: request codes are 3 bits wide; sideband levels are kept active high internally.
package idle_seq_pkg;

    localparam int REQ_W  = 3;
    localparam int DUTY_W = 3;

    // Request codes seen on req_state
    typedef enum logic [REQ_W-1:0] {
        RQ_C0 = 3'd0,
        RQ_C2 = 3'd1,
        RQ_C3 = 3'd2,
        RQ_C4 = 3'd3,
        RQ_S1 = 3'd4
    } req_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_C0,
        ST_ACK,
        ST_DPS,
        ST_CPU,
        ST_VLT,
        ST_SLP,
        ST_RES,
        ST_EXIT
    } seq_e;

    // Active-high view of the sideband outputs
    typedef struct packed {
        logic stpclk;
        logic dpslp;
        logic stpcpu;
        logic cpuslp;
        logic vlow;
        logic memblk;
    } side_t;

endpackage

// File: rtl/idle_step_timer.sv
// Down counter shared by the settle waits and the acknowledge timeout.
// A load takes priority; otherwise the count decrements until it reaches zero and holds there.
// Assumes: the caller loads before every wait it times.
module idle_step_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Load or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/idle_event_latch.sv
// Holds a posted state request and a wake event until the sequencer consumes them.
// A new request overwrites one still pending. Wake is dropped while in the full-on state.
// Assumes: req_take and wake_take are single-cycle consume strobes.
module idle_event_latch #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_take,
    input  logic              wake,
    input  logic              wake_take,
    input  logic              wake_flush,
    output logic              pend_vld,
    output logic [CODE_W-1:0] pend_code,
    output logic              wake_pend
);

    // Request holding register, newest request wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_code <= '0;
        end else if (req_valid) begin
            pend_vld  <= 1'b1;
            pend_code <= req_code;
        end else if (req_take) begin
            pend_vld  <= 1'b0;
        end
    end

    // Wake event flag, cleared when consumed or when already full-on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pend <= 1'b0;
        end else if (wake_take || wake_flush) begin
            wake_pend <= 1'b0;
        end else if (wake) begin
            wake_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/idle_throttle.sv
// Full-on throttle pattern: eight slots of (period+1) cycles each. The first
// 'duty' slots request stop-clock. Duty zero or disable holds the pattern at its start.
// Assumes: period and duty are quasi-static while enabled.
module idle_throttle #(
    parameter int PER_W  = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SLOT_W-1:0] duty,
    input  logic [PER_W-1:0]  period,
    output logic              thr_on
);

    logic [PER_W-1:0]  pcnt;
    logic [SLOT_W-1:0] slot;
    logic              run;

    assign run = en && (duty != '0);

    // Slot length counter and slot index
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt <= period;
            slot <= '0;
        end else if (pcnt == '0) begin
            pcnt <= period;
            slot <= slot + SLOT_W'(1);
        end else begin
            pcnt <= pcnt - PER_W'(1);
        end
    end

    assign thr_on = run && (slot < duty);

endmodule

// File: rtl/cpu_idle_seq.sv
// Processor idle state sequencer top. In the full-on state it takes a held request
// and runs the entry steps: stop-clock, acknowledge wait, deep-sleep plus memory
// block, clock stop, voltage lower. A settle count separates the steps. A wake
// releases the deepest asserted output one step at a time.
// Assumes: sg_ack and wake are synchronous to clk; all sideband outputs are registered.
module cpu_idle_seq
    import idle_seq_pkg::*;
#(
    parameter int SET_W = 4,
    parameter int TO_W  = 6,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_state,
    input  logic             s1_sleep_en,
    input  logic [2:0]       thr_duty,
    input  logic [PER_W-1:0] thr_period,
    input  logic [SET_W-1:0] settle,
    input  logic [TO_W-1:0]  ack_timeout,
    input  logic             sg_ack,
    input  logic             wake,
    output logic             stpclk_n,
    output logic             dpslp_n,
    output logic             stpcpu_n,
    output logic             cpuslp_n,
    output logic             vlow_n,
    output logic             mem_block,
    output logic             seq_err
);

    localparam int CNT_W = (SET_W > TO_W) ? SET_W : TO_W;

    seq_e              st, st_nx;
    side_t             q, q_nx;
    logic [REQ_W-1:0]  tgt, tgt_nx;
    logic              err_q, err_nx;
    logic              tmr_ld, tmr_zero;
    logic [CNT_W-1:0]  tmr_val, settle_ext, tmo_ext;
    logic              req_take, wake_take;
    logic              pend_vld, wake_pend;
    logic [REQ_W-1:0]  pend_code;
    logic              thr_on;

    assign settle_ext = CNT_W'(settle);
    assign tmo_ext    = CNT_W'(ack_timeout);

    idle_event_latch #(.CODE_W(REQ_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_code   (req_state),
        .req_take   (req_take),
        .wake       (wake),
        .wake_take  (wake_take),
        .wake_flush (st == ST_C0),
        .pend_vld   (pend_vld),
        .pend_code  (pend_code),
        .wake_pend  (wake_pend)
    );

    idle_step_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    idle_throttle #(.PER_W(PER_W), .SLOT_W(DUTY_W)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (st == ST_C0),
        .duty   (thr_duty),
        .period (thr_period),
        .thr_on (thr_on)
    );

    // Next state, next sideband levels and timer control
    always_comb begin
        st_nx     = st;
        q_nx      = q;
        tgt_nx    = tgt;
        err_nx    = err_q;
        tmr_ld    = 1'b0;
        tmr_val   = settle_ext;
        req_take  = 1'b0;
        wake_take = 1'b0;
        case (st)
            ST_C0: begin
                q_nx.stpclk = thr_on;
                if (pend_vld) begin
                    req_take = 1'b1;
                    case (pend_code)
                        RQ_C2, RQ_C3, RQ_C4, RQ_S1: begin
                            q_nx.stpclk = 1'b1;
                            tmr_ld      = 1'b1;
                            tmr_val     = tmo_ext;
                            tgt_nx      = pend_code;
                            err_nx      = 1'b0;
                            st_nx       = ST_ACK;
                        end
                        default: ;
                    endcase
                end
            end
            ST_ACK: begin
                if (sg_ack) begin
                    tmr_ld = 1'b1;
                    case (tgt)
                        RQ_C3, RQ_C4: st_nx = ST_DPS;
                        RQ_S1:        st_nx = s1_sleep_en ? ST_SLP : ST_RES;
                        default:      st_nx = ST_RES;
                    endcase
                end else if (tmr_zero) begin
                    q_nx.stpclk = 1'b0;
                    err_nx      = 1'b1;
                    st_nx       = ST_C0;
                end
            end
            ST_DPS: begin
                if (tmr_zero) begin
                    q_nx.dpslp  = 1'b1;
                    q_nx.memblk = 1'b1;
                    tmr_ld      = 1'b1;
                    st_nx       = ST_CPU;
                end
            end
            ST_CPU: begin
                if (tmr_zero) begin
                    q_nx.stpcpu = 1'b1;
                    tmr_ld      = 1'b1;
                    st_nx       = (tgt == RQ_C4) ? ST_VLT : ST_RES;
                end
            end
            ST_VLT: begin
                if (tmr_zero) begin
                    q_nx.vlow = 1'b1;
                    st_nx     = ST_RES;
                end
            end
            ST_SLP: begin
                if (tmr_zero) begin
                    q_nx.cpuslp = 1'b1;
                    st_nx       = ST_RES;
                end
            end
            ST_RES: begin
                if (wake_pend) begin
                    wake_take = 1'b1;
                    tmr_ld    = 1'b1;
                    st_nx     = ST_EXIT;
                end
            end
            ST_EXIT: begin
                if (tmr_zero) begin
                    tmr_ld = 1'b1;
                    if (q.vlow) begin
                        q_nx.vlow = 1'b0;
                    end else if (q.stpcpu) begin
                        q_nx.stpcpu = 1'b0;
                    end else if (q.dpslp) begin
                        q_nx.dpslp  = 1'b0;
                        q_nx.memblk = 1'b0;
                    end else if (q.cpuslp) begin
                        q_nx.cpuslp = 1'b0;
                    end else begin
                        q_nx.stpclk = 1'b0;
                        st_nx       = ST_C0;
                    end
                end
            end
            default: st_nx = ST_C0;
        endcase
    end

    // State, sideband and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_C0;
            q     <= '0;
            tgt   <= RQ_C0;
            err_q <= 1'b0;
        end else begin
            st    <= st_nx;
            q     <= q_nx;
            tgt   <= tgt_nx;
            err_q <= err_nx;
        end
    end

    assign stpclk_n  = ~q.stpclk;
    assign dpslp_n   = ~q.dpslp;
    assign stpcpu_n  = ~q.stpcpu;
    assign cpuslp_n  = ~q.cpuslp;
    assign vlow_n    = ~q.vlow;
    assign mem_block = q.memblk;
    assign seq_err   = err_q;

endmodule

// File: rtl/idle_seq_chk.sv
// Ordering checks on the sequencer ports, bound into every cpu_idle_seq instance.
// Assumes: rst_n is held low over the first clock edges.
module idle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic stpclk_n,
    input logic dpslp_n,
    input logic stpcpu_n,
    input logic cpuslp_n,
    input logic vlow_n,
    input logic mem_block,
    input logic seq_err
);

    AST_DPS_UNDER_STP: assert property (@(posedge clk) disable iff (!rst_n) !dpslp_n |-> !stpclk_n); // R3
    AST_CPU_UNDER_DPS: assert property (@(posedge clk) disable iff (!rst_n) !stpcpu_n |-> !dpslp_n); // R3
    AST_MEM_WITH_DPS:  assert property (@(posedge clk) disable iff (!rst_n) !dpslp_n |-> mem_block); // R4
    AST_MEM_ONLY_DPS:  assert property (@(posedge clk) disable iff (!rst_n) mem_block |-> !dpslp_n); // R4
    AST_VLT_UNDER_CPU: assert property (@(posedge clk) disable iff (!rst_n) !vlow_n |-> !stpcpu_n); // R5
    AST_SLP_S1_ONLY:   assert property (@(posedge clk) disable iff (!rst_n) !cpuslp_n |-> (!stpclk_n && dpslp_n)); // R6
    AST_DPS_REL_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $rose(dpslp_n) |-> (!stpclk_n && stpcpu_n)); // R7
    AST_CPU_REL_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $rose(stpcpu_n) |-> (!dpslp_n && vlow_n)); // R7
    AST_ERR_RELEASES:  assert property (@(posedge clk) disable iff (!rst_n) $rose(seq_err) |-> stpclk_n); // R9

endmodule

bind cpu_idle_seq idle_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stpclk_n  (stpclk_n),
    .dpslp_n   (dpslp_n),
    .stpcpu_n  (stpcpu_n),
    .cpuslp_n  (cpuslp_n),
    .vlow_n    (vlow_n),
    .mem_block (mem_block),
    .seq_err   (seq_err)
);

// File: tb/sim_cpu_idle_seq.sv
module sim_cpu_idle_seq;

    localparam int SW = 4;
    localparam int TW = 4;
    localparam int PW = 4;
    localparam int WD = 60000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_state = 3'd0;
    logic          s1_sleep_en = 1'b0;
    logic [2:0]    thr_duty = 3'd0;
    logic [PW-1:0] thr_period = '0;
    logic [SW-1:0] settle = '0;
    logic [TW-1:0] ack_timeout = 4'd5;
    logic          ack_auto = 1'b0, ack_auto_en = 1'b1, ack_man = 1'b0;
    logic          wake = 1'b0;
    logic          sg_ack;
    logic          stpclk_n, dpslp_n, stpcpu_n, cpuslp_n, vlow_n, mem_block, seq_err;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    int tf[6];
    int tr[6];
    logic [5:0] prevv = '0;
    logic [5:0] actv;

    always #4 clk = ~clk;

    assign sg_ack = ack_auto | ack_man;
    assign actv = {mem_block, ~vlow_n, ~cpuslp_n, ~stpcpu_n, ~dpslp_n, ~stpclk_n};

    cpu_idle_seq #(.SET_W(SW), .TO_W(TW), .PER_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
        .s1_sleep_en(s1_sleep_en), .thr_duty(thr_duty), .thr_period(thr_period),
        .settle(settle), .ack_timeout(ack_timeout), .sg_ack(sg_ack), .wake(wake),
        .stpclk_n(stpclk_n), .dpslp_n(dpslp_n), .stpcpu_n(stpcpu_n), .cpuslp_n(cpuslp_n),
        .vlow_n(vlow_n), .mem_block(mem_block), .seq_err(seq_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Processor model: acknowledge one cycle after stop-clock is seen
    always @(negedge clk) ack_auto <= ack_auto_en & ~stpclk_n;

    // Edge-index recorder of every assertion and release
    always @(negedge clk) begin
        for (int i = 0; i < 6; i++) begin
            if (actv[i] === 1'b1 && prevv[i] === 1'b0) tf[i] = cyc;
            if (actv[i] === 1'b0 && prevv[i] === 1'b1) tr[i] = cyc;
        end
        prevv = actv;
    end

    always @(posedge clk) begin
        if (cyc == WD) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog act=%0d exp=<%0d", cyc, WD);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic chk(input string tag, input int a, input int e);
        nchk++;
        if (a != e) begin
            nerr++;
            $display("FAIL %s act=%0d exp=%0d", tag, a, e);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_t();
        for (int i = 0; i < 6; i++) begin
            tf[i] = -1;
            tr[i] = -1;
        end
    endtask

    task automatic send_req(input logic [2:0] c, output int t);
        @(negedge clk);
        req_state = c;
        req_valid = 1'b1;
        t = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_wake(output int t);
        @(negedge clk);
        wake = 1'b1;
        t = cyc + 1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    function automatic int all_idle();
        return (stpclk_n && dpslp_n && stpcpu_n && cpuslp_n && vlow_n && !mem_block) ? 1 : 0;
    endfunction

    // One full entry, residence and exit with timing checks
    task automatic run_state(input logic [2:0] c, input int s, input logic en);
        int tq, tw, a, e;
        int ord[5];
        logic [4:0] used;
        ord = '{4, 2, 1, 3, 0};
        settle = SW'(s);
        s1_sleep_en = en;
        used = 5'b00001;
        if (c == 3'd2 || c == 3'd3) used[2:1] = 2'b11;
        if (c == 3'd3) used[4] = 1'b1;
        if (c == 3'd4 && en) used[3] = 1'b1;
        clr_t();
        send_req(c, tq);
        tick(4 * s + 12);
        chk("R2 stpclk one edge after request", tf[0], tq + 1);
        a = tq + 2;
        if (used[1]) begin
            chk("R3 dpslp after ack", tf[1], a + s + 1);
            chk("R3 stpcpu after dpslp", tf[2], a + 2 * s + 2);
            chk("R4 mem_block with dpslp", tf[5], tf[1]);
        end else begin
            chk("R2 R6 no deep outputs", {dpslp_n, stpcpu_n, mem_block}, 3'b110);
        end
        if (used[4]) chk("R5 vlow after stpcpu", tf[4], a + 3 * s + 3);
        else chk("R5 vlow idle", vlow_n, 1);
        if (used[3]) chk("R6 cpuslp after ack", tf[3], a + s + 1);
        else chk("R6 cpuslp idle", cpuslp_n, 1);
        clr_t();
        send_wake(tw);
        tick(6 * s + 14);
        e = tw + s + 2;
        for (int k = 0; k < 5; k++) begin
            if (used[ord[k]]) begin
                chk($sformatf("R7 release of output %0d", ord[k]), tr[ord[k]], e);
                e = e + s + 1;
            end
        end
        if (used[1]) chk("R4 mem_block drops with dpslp", tr[5], tr[1]);
        chk("R7 all released", all_idle(), 1);
    endtask

    initial begin
        int tq, tw, cnt;
        clr_t();
        tick(5);
        chk("R1 outputs in reset", {all_idle(), 31'(seq_err)}, {1'b1, 31'd0});
        rst_n = 1'b1;
        tick(3);
        chk("R1 outputs after reset", {all_idle(), 31'(seq_err)}, {1'b1, 31'd0});

        // R8 throttle duty sweep over two slot lengths
        for (int p = 0; p < 4; p += 3) begin
            for (int d = 0; d < 8; d++) begin
                thr_period = PW'(p);
                thr_duty = 3'(d);
                tick(8 * (p + 1) + 4);
                cnt = 0;
                repeat (8 * (p + 1)) begin
                    @(negedge clk);
                    if (!stpclk_n) cnt++;
                end
                chk($sformatf("R8 throttle low count d=%0d p=%0d", d, p), cnt, d * (p + 1));
                thr_duty = 3'd0;
                tick(3);
            end
        end

        // R2..R7 entry and exit for every target and settle
        for (int s = 0; s < 4; s += 2) begin
            run_state(3'd1, s, 1'b0);
            run_state(3'd2, s, 1'b0);
            run_state(3'd3, s, 1'b0);
            run_state(3'd4, s, 1'b0);
            run_state(3'd4, s, 1'b1);
        end

        // R2 null request code changes nothing
        send_req(3'd0, tq);
        tick(10);
        chk("R2 code 0 no effect", all_idle(), 1);

        // R9 timeout boundary
        settle = SW'(1);
        ack_timeout = TW'(3);
        ack_auto_en = 1'b0;
        send_req(3'd2, tq);
        tick(1);
        tick(3);
        chk("R9 still waiting at last count", {stpclk_n, seq_err}, 2'b00);
        tick(1);
        chk("R9 abort releases and flags", {stpclk_n, seq_err}, 2'b11);
        tick(4);
        // R9 acknowledge on the expiring cycle wins, error cleared on acceptance
        send_req(3'd2, tq);
        tick(1);
        tick(3);
        chk("R9 error cleared by new request", seq_err, 0);
        ack_man = 1'b1;
        tick(20);
        chk("R9 ack at expiry proceeds", {dpslp_n, seq_err}, 2'b00);
        send_wake(tw);
        tick(20);
        ack_man = 1'b0;
        ack_auto_en = 1'b1;
        chk("R9 exit after late ack", all_idle(), 1);

        // R10 request held during residence, started after exit
        send_req(3'd1, tq);
        tick(10);
        send_req(3'd2, tq);
        tick(15);
        chk("R10 held request not started", dpslp_n, 1);
        clr_t();
        send_wake(tw);
        tick(30);
        chk("R10 stpclk released on schedule", tr[0], tw + 3);
        chk("R10 held request starts next edge", tf[0], tr[0] + 1);
        chk("R10 held C3 reaches deep sleep", (tf[1] > tf[0]) ? 1 : 0, 1);
        send_wake(tw);
        tick(30);
        chk("R10 exit after held request", all_idle(), 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule